// File: doc/BRIEF.md
# Multi-width integer ALU

This is a purely combinational integer datapath for a 64-bit register machine. The operations are add, subtract, multiply, the three bitwise logic functions, left shift, logical and arithmetic right shift, an unsigned and a signed three-way compare, bitwise complement, logical negation and sign extension. Each operation takes two 64-bit operands and returns one 64-bit value in the same cycle. A two-bit width selector picks 8, 16, 32 or 64 bits for the arithmetic and shift operations. Those results wrap at the chosen width and come back zero-extended.

Compare does not set flags. It produces a register value of -1, 0 or +1. Complement and logical negation are separate operations. Sign extension reads the same width selector to decide which low slice of operand A holds the sign.

Top module: `int_alu_mw`

Operation codes on `op_i`: 0 add, 1 subtract, 2 multiply, 3 AND, 4 OR, 5 XOR, 6 left shift, 7 logical right shift, 8 arithmetic right shift, 9 unsigned compare, 10 signed compare, 11 complement, 12 logical NOT, 13 sign extend. Width codes on `wid_i`: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits.

## Requirements
- R1: Op 0 (add) returns (A+B) mod 2^w, zero-extended to 64 bits, where w is the width selected by wid_i (0→8, 1→16, 2→32, 3→64).
- R2: Op 1 (subtract) returns (A−B) mod 2^w, zero-extended to 64 bits.
- R3: Op 2 (multiply) returns the low w bits of A×B, zero-extended to 64 bits.
- R4: Ops 3, 4 and 5 return the 64-bit AND, OR and XOR of A and B for every value of wid_i.
- R5: Op 6 (left shift) returns the low w bits of A shifted left by (B mod w), zero-extended. Bits moved past bit w−1 are lost.
- R6: Op 7 (logical right shift) shifts the low w bits of A right by (B mod w) and fills with zeros. Bits of A above w have no effect.
- R7: Op 8 (arithmetic right shift) shifts the low w bits of A right by (B mod w) and fills with bit w−1 of A. The result is the low w bits, zero-extended.
- R8: Op 9 (unsigned compare) treats both 64-bit operands as unsigned. It returns all ones (−1) when A<B, 0 when A=B and 1 when A>B, whatever wid_i holds.
- R9: Op 10 (signed compare) does the same on full 64-bit two's complement operands.
- R10: Op 11 (complement) returns the bitwise inverse of all 64 bits of A.
- R11: Op 12 (logical NOT) returns 1 when all 64 bits of A are zero, and 0 otherwise.
- R12: Op 13 (sign extend) copies bit w−1 of A into all higher bits for wid_i 0, 1 and 2, and passes A through unchanged for wid_i 3.
- R13: Codes 14 and 15 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code |
| wid_i | input | 2 | Operand width select (0→8, 1→16, 2→32, 3→64 bits) |
| opa_i | input | 64 | Operand A |
| opb_i | input | 64 | Operand B, or the shift amount |
| res_o | output | 64 | Result |

## Verification
The block holds no state, so a fault shows on `res_o` in the same cycle as the operands that trigger it. The likely faults are a wrong lane, a missing mask or the wrong sign bit. A missing mask leaves nonzero bits above the selected width, so vectors are chosen to carry into, or arrive from, those upper bits. A shift that uses bit 63 instead of the lane sign, or that takes the amount modulo 64 instead of modulo w, changes the sub-width results. Boundary values such as all ones, a lone top bit and shift amounts equal to the width expose those errors directly.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

    parameter int XLEN  = 64;
    parameter int NLANE = 4;                 // 8,16,32,64-bit lanes
    localparam int SHW  = $clog2(XLEN);

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_MUL  = 4'd2,
        OP_AND  = 4'd3,
        OP_OR   = 4'd4,
        OP_XOR  = 4'd5,
        OP_SLL  = 4'd6,
        OP_SRL  = 4'd7,
        OP_SRA  = 4'd8,
        OP_CMPU = 4'd9,
        OP_CMPS = 4'd10,
        OP_INV  = 4'd11,
        OP_LNOT = 4'd12,
        OP_SEXT = 4'd13
    } alu_op_e;

    typedef enum logic [1:0] {
        WID_8  = 2'd0,
        WID_16 = 2'd1,
        WID_32 = 2'd2,
        WID_64 = 2'd3
    } alu_wid_e;

    typedef struct packed {
        logic [XLEN-1:0] a;
        logic [XLEN-1:0] b;
    } alu_opnd_s;

    // Mask covering the low bits of the selected width.
    function automatic logic [XLEN-1:0] lane_mask(alu_wid_e w);
        logic [XLEN-1:0] m;
        m = '0;
        for (int i = 0; i < XLEN; i++) begin
            m[i] = (i < (8 << w));
        end
        return m;
    endfunction

    // Replicate bit (width-1) of v into all higher bits.
    function automatic logic [XLEN-1:0] sign_fill(logic [XLEN-1:0] v, alu_wid_e w);
        logic [XLEN-1:0] r;
        case (w)
            WID_8:   r = {{(XLEN-8){v[7]}},   v[7:0]};
            WID_16:  r = {{(XLEN-16){v[15]}}, v[15:0]};
            WID_32:  r = {{(XLEN-32){v[31]}}, v[31:0]};
            default: r = v;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/alu_arith_unit.sv
module alu_arith_unit
    import int_alu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  alu_opnd_s opnd_i,
    input  alu_wid_e  wid_i,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] diff_o,
    output logic [W-1:0] prod_o
);
    logic [W-1:0] mask;
    logic [W-1:0] sum_full;
    logic [W-1:0] diff_full;
    logic [W-1:0] prod_full;

    // Low bits of a two's complement sum, difference or product do not
    // depend on higher bits, so a full-width operation then a mask wraps
    // correctly at every lane width.
    always_comb begin
        mask      = lane_mask(wid_i);
        sum_full  = opnd_i.a + opnd_i.b;
        diff_full = opnd_i.a - opnd_i.b;
        prod_full = opnd_i.a * opnd_i.b;
        sum_o     = sum_full  & mask;
        diff_o    = diff_full & mask;
        prod_o    = prod_full & mask;
    end

endmodule

// File: rtl/alu_shift_unit.sv
module alu_shift_unit
    import int_alu_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int NL = NLANE,
    localparam int AW = $clog2(W)
) (
    input  logic [W-1:0]  val_i,
    input  logic [AW-1:0] amt_i,
    input  alu_wid_e      wid_i,
    output logic [W-1:0]  sll_o,
    output logic [W-1:0]  srl_o,
    output logic [W-1:0]  sra_o
);
    logic [W-1:0] sll_lane [NL];
    logic [W-1:0] srl_lane [NL];
    logic [W-1:0] sra_lane [NL];

    for (genvar g = 0; g < NL; g++) begin : g_lane
        localparam int LW  = 8 << g;
        localparam int LSH = $clog2(LW);

        logic [LW-1:0]  src;
        logic [LSH-1:0] sh;
        logic [LW-1:0]  l_sll;
        logic [LW-1:0]  l_srl;
        logic [LW-1:0]  l_sra;

        assign src   = val_i[LW-1:0];
        assign sh    = amt_i[LSH-1:0];          // amount modulo lane width
        assign l_sll = src << sh;
        assign l_srl = src >> sh;
        assign l_sra = $signed(src) >>> sh;      // lane sign, not bit 63

        assign sll_lane[g] = W'(l_sll);
        assign srl_lane[g] = W'(l_srl);
        assign sra_lane[g] = W'(l_sra);
    end

    always_comb begin
        sll_o = sll_lane[wid_i];
        srl_o = srl_lane[wid_i];
        sra_o = sra_lane[wid_i];
    end

endmodule

// File: rtl/alu_cmp_unit.sv
module alu_cmp_unit
    import int_alu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  alu_opnd_s    opnd_i,
    output logic [W-1:0] cmpu_o,
    output logic [W-1:0] cmps_o
);
    localparam logic [W-1:0] NEG_ONE = '1;
    localparam logic [W-1:0] POS_ONE = W'(1);

    logic ult, slt, eq;

    always_comb begin
        eq  = (opnd_i.a == opnd_i.b);
        ult = (opnd_i.a < opnd_i.b);
        slt = ($signed(opnd_i.a) < $signed(opnd_i.b));

        if (eq)       cmpu_o = '0;
        else if (ult) cmpu_o = NEG_ONE;
        else          cmpu_o = POS_ONE;

        if (eq)       cmps_o = '0;
        else if (slt) cmps_o = NEG_ONE;
        else          cmps_o = POS_ONE;
    end

endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
    import int_alu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  alu_opnd_s    opnd_i,
    input  alu_wid_e     wid_i,
    output logic [W-1:0] and_o,
    output logic [W-1:0] or_o,
    output logic [W-1:0] xor_o,
    output logic [W-1:0] inv_o,
    output logic [W-1:0] lnot_o,
    output logic [W-1:0] sext_o
);
    always_comb begin
        and_o  = opnd_i.a & opnd_i.b;
        or_o   = opnd_i.a | opnd_i.b;
        xor_o  = opnd_i.a ^ opnd_i.b;
        inv_o  = ~opnd_i.a;
        lnot_o = W'(opnd_i.a == '0);
        sext_o = sign_fill(opnd_i.a, wid_i);
    end

endmodule

// File: rtl/int_alu_mw.sv
module int_alu_mw
    import int_alu_pkg::*;
(
    input  logic [3:0]  op_i,
    input  logic [1:0]  wid_i,
    input  logic [63:0] opa_i,
    input  logic [63:0] opb_i,
    output logic [63:0] res_o
);
    alu_op_e   op;
    alu_wid_e  wid;
    alu_opnd_s opnd;

    logic [XLEN-1:0] r_add, r_sub, r_mul;
    logic [XLEN-1:0] r_sll, r_srl, r_sra;
    logic [XLEN-1:0] r_cmpu, r_cmps;
    logic [XLEN-1:0] r_and, r_or, r_xor, r_inv, r_lnot, r_sext;

    assign op     = alu_op_e'(op_i);
    assign wid    = alu_wid_e'(wid_i);
    assign opnd.a = opa_i;
    assign opnd.b = opb_i;

    alu_arith_unit #(.W(XLEN)) u_arith (
        .opnd_i (opnd),
        .wid_i  (wid),
        .sum_o  (r_add),
        .diff_o (r_sub),
        .prod_o (r_mul)
    );

    alu_shift_unit #(.W(XLEN), .NL(NLANE)) u_shift (
        .val_i (opa_i),
        .amt_i (opb_i[SHW-1:0]),
        .wid_i (wid),
        .sll_o (r_sll),
        .srl_o (r_srl),
        .sra_o (r_sra)
    );

    alu_cmp_unit #(.W(XLEN)) u_cmp (
        .opnd_i (opnd),
        .cmpu_o (r_cmpu),
        .cmps_o (r_cmps)
    );

    alu_logic_unit #(.W(XLEN)) u_logic (
        .opnd_i (opnd),
        .wid_i  (wid),
        .and_o  (r_and),
        .or_o   (r_or),
        .xor_o  (r_xor),
        .inv_o  (r_inv),
        .lnot_o (r_lnot),
        .sext_o (r_sext)
    );

    always_comb begin
        case (op)
            OP_ADD:  res_o = r_add;
            OP_SUB:  res_o = r_sub;
            OP_MUL:  res_o = r_mul;
            OP_AND:  res_o = r_and;
            OP_OR:   res_o = r_or;
            OP_XOR:  res_o = r_xor;
            OP_SLL:  res_o = r_sll;
            OP_SRL:  res_o = r_srl;
            OP_SRA:  res_o = r_sra;
            OP_CMPU: res_o = r_cmpu;
            OP_CMPS: res_o = r_cmps;
            OP_INV:  res_o = r_inv;
            OP_LNOT: res_o = r_lnot;
            OP_SEXT: res_o = r_sext;
            default: res_o = '0;
        endcase
    end

endmodule

// File: rtl/int_alu_mw_chk.sv
module int_alu_mw_chk
    import int_alu_pkg::*;
(
    input logic [3:0]  op_i,
    input logic [1:0]  wid_i,
    input logic [63:0] opa_i,
    input logic [63:0] opb_i,
    input logic [63:0] res_o
);
    alu_op_e  op;
    alu_wid_e wid;
    logic     narrow_op;
    logic [63:0] hi_mask;
    logic [7:0]  low_sum;

    assign op  = alu_op_e'(op_i);
    assign wid = alu_wid_e'(wid_i);

    always_comb begin
        narrow_op = (op == OP_ADD) || (op == OP_SUB) || (op == OP_MUL) ||
                    (op == OP_SLL) || (op == OP_SRL) || (op == OP_SRA);
        hi_mask   = ~lane_mask(wid);
        low_sum   = opa_i[7:0] + opb_i[7:0];

        // R1, R2, R3, R5, R6, R7: nothing above the selected width
        if (narrow_op)
            assert_subwidth_zext_R1: assert ((res_o & hi_mask) == '0)
                else $error("upper bits set above selected width");

        if (op == OP_ADD)
            assert_add_lowbyte_R1: assert (res_o[7:0] == low_sum)
                else $error("low byte of sum wrong");

        if (op == OP_AND)
            assert_and_subset_R4: assert (((res_o & ~opa_i) == '0) && ((res_o & ~opb_i) == '0))
                else $error("AND result has bits not in both operands");

        if ((op == OP_CMPU) || (op == OP_CMPS))
            assert_cmp_range_R8: assert ((res_o == '0) || (res_o == 64'd1) || (res_o == '1))
                else $error("compare value out of range");

        if ((op == OP_CMPU) && (opa_i < opb_i))
            assert_cmpu_less_R8: assert (res_o == '1)
                else $error("unsigned less-than not -1");

        if ((op == OP_CMPS) && (opa_i == opb_i))
            assert_cmps_equal_R9: assert (res_o == '0)
                else $error("signed equal not 0");

        if (op == OP_INV)
            assert_inv_all_R10: assert ((res_o ^ opa_i) == '1)
                else $error("complement mismatch");

        if (op == OP_LNOT)
            assert_lnot_bool_R11: assert (res_o == {63'd0, opa_i == '0})
                else $error("logical NOT mismatch");

        if ((op == OP_SEXT) && (wid == WID_8))
            assert_sext_upper_R12: assert ((res_o[63:7] == '0) || (res_o[63:7] == '1))
                else $error("sign extension upper bits not uniform");

        if (op_i > 4'd13)
            assert_undef_zero_R13: assert (res_o == '0)
                else $error("undefined opcode gave nonzero result");
    end

endmodule

bind int_alu_mw int_alu_mw_chk u_chk (
    .op_i  (op_i),
    .wid_i (wid_i),
    .opa_i (opa_i),
    .opb_i (opb_i),
    .res_o (res_o)
);

// File: tb/int_alu_mw_test.sv
`timescale 1ns/1ps
module int_alu_mw_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op  = 4'd0;
    logic [1:0]  wid = 2'd0;
    logic [63:0] a   = 64'd0;
    logic [63:0] b   = 64'd0;
    logic [63:0] res;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

    always #2 clk = ~clk;   // 250 MHz

    int_alu_mw uut (
        .op_i  (op),
        .wid_i (wid),
        .opa_i (a),
        .opb_i (b),
        .res_o (res)
    );

    task automatic run(input string tag, input logic [3:0] o, input logic [1:0] w,
                       input logic [63:0] x, input logic [63:0] y, input logic [63:0] exp);
        @(posedge clk);
        op = o; wid = w; a = x; b = y;
        @(negedge clk);
        checks++;
        if (res !== exp) begin
            errors++;
            $display("FAIL %s op=%0d wid=%0d a=%h b=%h got=%h exp=%h", tag, o, w, x, y, res, exp);
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        checks++;
        if (res !== 64'd0) begin
            errors++;
            $display("FAIL R1 reset-state got=%h exp=%h", res, 64'd0);
        end
        rst = 1'b0;
    endtask

    task automatic t_add;
        run("R1", 4'd0, 2'd0, 64'h0000_0000_0000_00FF, 64'd1, 64'd0);
        run("R1", 4'd0, 2'd1, 64'h1234_5678_9ABC_DEF0, 64'h10, 64'h0000_0000_0000_DF00);
        run("R1", 4'd0, 2'd2, 64'h0000_0000_7FFF_FFFF, 64'd1, 64'h0000_0000_8000_0000);
        run("R1", 4'd0, 2'd3, ONES, 64'd2, 64'd1);
    endtask

    task automatic t_sub;
        run("R2", 4'd1, 2'd0, 64'd0, 64'd1, 64'h0000_0000_0000_00FF);
        run("R2", 4'd1, 2'd3, 64'd5, 64'd7, 64'hFFFF_FFFF_FFFF_FFFE);
        run("R2", 4'd1, 2'd1, 64'hAAAA_0000_0000_0000, 64'd1, 64'h0000_0000_0000_FFFF);
    endtask

    task automatic t_mul;
        run("R3", 4'd2, 2'd0, 64'h10, 64'h10, 64'd0);
        run("R3", 4'd2, 2'd0, 64'h0F, 64'h0F, 64'hE1);
        run("R3", 4'd2, 2'd1, 64'h0100, 64'h0100, 64'd0);
        run("R3", 4'd2, 2'd1, 64'h00FF, 64'h3, 64'h02FD);
        run("R3", 4'd2, 2'd3, ONES, 64'd3, 64'hFFFF_FFFF_FFFF_FFFD);
    endtask

    task automatic t_logic;
        run("R4", 4'd3, 2'd0, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, 64'hF000_F000_F000_F000);
        run("R4", 4'd4, 2'd1, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, 64'hFFF0_FFF0_FFF0_FFF0);
        run("R4", 4'd5, 2'd2, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, 64'h0FF0_0FF0_0FF0_0FF0);
    endtask

    task automatic t_sll;
        run("R5", 4'd6, 2'd0, 64'h81, 64'd1, 64'h02);
        run("R5", 4'd6, 2'd0, 64'h81, 64'd9, 64'h02);
        run("R5", 4'd6, 2'd3, 64'd1, 64'd63, 64'h8000_0000_0000_0000);
        run("R5", 4'd6, 2'd3, 64'd1, 64'd64, 64'd1);
        run("R5", 4'd6, 2'd2, 64'hAAAA_0000_0000_0003, 64'd4, 64'h30);
    endtask

    task automatic t_srl;
        run("R6", 4'd7, 2'd0, 64'hFF80, 64'd7, 64'd1);
        run("R6", 4'd7, 2'd1, 64'hFFFF_FFFF_FFFF_8000, 64'd15, 64'd1);
        run("R6", 4'd7, 2'd3, 64'h8000_0000_0000_0000, 64'd63, 64'd1);
        run("R6", 4'd7, 2'd0, 64'hFF00, 64'd0, 64'd0);
    endtask

    task automatic t_sra;
        run("R7", 4'd8, 2'd0, 64'h80, 64'd7, 64'hFF);
        run("R7", 4'd8, 2'd0, 64'h40, 64'd6, 64'h01);
        run("R7", 4'd8, 2'd0, 64'h7F80, 64'd1, 64'hC0);
        run("R7", 4'd8, 2'd1, 64'h8000, 64'd4, 64'hF800);
        run("R7", 4'd8, 2'd2, 64'h0000_0000_8000_0000, 64'd31, 64'hFFFF_FFFF);
        run("R7", 4'd8, 2'd3, 64'h8000_0000_0000_0000, 64'd4, 64'hF800_0000_0000_0000);
        run("R7", 4'd8, 2'd1, 64'h8000_0000_0000_4000, 64'd2, 64'h1000);
    endtask

    task automatic t_cmp;
        run("R8", 4'd9, 2'd3, 64'd1, ONES, ONES);
        run("R8", 4'd9, 2'd3, 64'd77, 64'd77, 64'd0);
        run("R8", 4'd9, 2'd3, ONES, 64'd1, 64'd1);
        run("R8", 4'd9, 2'd0, 64'h100, 64'h1, 64'd1);
        run("R9", 4'd10, 2'd3, ONES, 64'd1, ONES);
        run("R9", 4'd10, 2'd3, 64'd1, ONES, 64'd1);
        run("R9", 4'd10, 2'd0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'd0);
        run("R9", 4'd10, 2'd0, 64'h0000_0000_0000_0080, 64'h1, 64'd1);
    endtask

    task automatic t_unary;
        run("R10", 4'd11, 2'd0, 64'h00FF_00FF_00FF_00FF, 64'd0, 64'hFF00_FF00_FF00_FF00);
        run("R11", 4'd12, 2'd3, 64'd0, 64'd5, 64'd1);
        run("R11", 4'd12, 2'd3, 64'h8000_0000_0000_0000, 64'd0, 64'd0);
        run("R11", 4'd12, 2'd0, 64'h100, 64'd0, 64'd0);
    endtask

    task automatic t_sext;
        run("R12", 4'd13, 2'd0, 64'h1234_0080, 64'd0, 64'hFFFF_FFFF_FFFF_FF80);
        run("R12", 4'd13, 2'd0, 64'hFF7F, 64'd0, 64'h7F);
        run("R12", 4'd13, 2'd1, 64'hABCD_8001, 64'd0, 64'hFFFF_FFFF_FFFF_8001);
        run("R12", 4'd13, 2'd2, 64'h1_7FFF_FFFF, 64'd0, 64'h7FFF_FFFF);
        run("R12", 4'd13, 2'd3, 64'h8123_4567_89AB_CDEF, 64'd0, 64'h8123_4567_89AB_CDEF);
    endtask

    task automatic t_undef;
        run("R13", 4'd14, 2'd3, ONES, ONES, 64'd0);
        run("R13", 4'd15, 2'd0, 64'h55, 64'hAA, 64'd0);
    endtask

    initial begin
        t_reset;
        t_add;
        t_sub;
        t_mul;
        t_logic;
        t_sll;
        t_srl;
        t_sra;
        t_cmp;
        t_unary;
        t_sext;
        t_undef;
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
        end
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog expired got=timeout exp=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
        end
        $finish;
    end

endmodule